// File: doc/BRIEF.md
# Byte Stream to Multilane Packer

The packer receives a packet stream one byte per transfer, under a valid/ready handshake, with a flag that marks the end of each packet. It gathers those bytes into words of `LANES` byte lanes. Each word goes out with a count of the lanes that are filled and its own end-of-packet flag. A packet always opens in lane 0 of a new word, so bytes from two packets never share one word. Filled lanes are always contiguous from lane 0, and every unused lane is driven to zero.

Some packets have no byte left to send when they end. An input beat can close such a packet without carrying a byte: it sets both the end flag and the no-byte flag. For this case the packer emits a word with the bytes still held, and that count may be 0. This covers empty packets, and it also covers packets that the sender ends after a full word has already gone out. When the end flag instead arrives with the byte that fills the last lane, the word goes out with count `LANES` and its end flag set. A word with count `LANES` and the end flag clear is a full word in the middle of a packet, so the two cases stay distinct.

The assembly register is also the output register. When the output drains a word in a cycle, the input can load the first byte of the next word in that same cycle.

Top module: `pkt_lane_packer`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Bytes of a packet fill lanes in arrival order. Lane i sits at out_data[8*i +: 8], and lane 0 holds the earliest byte. A word whose out_last is 0 always has out_len equal to LANES.
- R3: Every packet opens in lane 0 of a new word. One word never carries bytes from two packets.
- R4: An input byte with in_last=1 and in_empty=0 ends the packet. If that byte fills lane LANES-1, the word has out_len=LANES and out_last=1.
- R5: An input beat with in_last=1 and in_empty=1 carries no byte. It emits the k bytes held so far (0 ≤ k < LANES) with out_len=k and out_last=1. A packet with no bytes gives out_len=0, out_last=1.
- R6: Lanes at index out_len and above read zero while out_valid is high.
- R7: While out_valid=1 and out_ready=0, out_data, out_len and out_last do not change, and out_valid stays high.
- R8: in_ready equals (!out_valid || out_ready). When a word drains, a byte can be taken into lane 0 of the next word in the same cycle.
- R9: A beat with in_empty=1 and in_last=0 is consumed and has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Packer accepts the input beat |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Beat ends the packet |
| in_empty | input | 1 | Beat carries no byte |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | LANES*8 | Lane array, lane 0 in the low byte |
| out_len | output | $clog2(LANES+1) | Number of filled lanes, 0 to LANES |
| out_last | output | 1 | Word ends the packet |

## Verification
Draining a finished word and loading the first byte of the next word can happen on the same edge. The stimulus provokes this by holding in_valid high while out_ready is drawn at random, with a high probability of acceptance. Packets are also sent back to back, including packets whose size is an exact multiple of LANES. Every drained word is compared with a reference list built by the bench from the packet contents. A byte lost or misplaced at a drain-and-load edge therefore appears as a wrong lane, a wrong count or a wrong end flag. On every cycle the bench also checks in_ready against the output handshake.

// File: rtl/pkt_lane_packer.sv
module pkt_lane_packer #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LEN_W  = $clog2(LANES + 1),
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_empty,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_last
);

  logic              word_q, last_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;

  logic              drain, take, done;
  logic [LEN_W-1:0]  base_cnt, cnt_n;
  logic [DATA_W-1:0] base_data, data_n;

  assign drain     = word_q & out_ready;
  assign in_ready  = ~word_q | out_ready;
  assign take      = in_valid & in_ready;
  assign base_cnt  = drain ? '0 : cnt_q;
  assign base_data = drain ? '0 : data_q;

  always_comb begin
    data_n = base_data;
    cnt_n  = base_cnt;
    done   = 1'b0;
    if (take) begin
      if (!in_empty) begin
        for (int i = 0; i < LANES; i++)
          if (LEN_W'(i) == base_cnt) data_n[i*BYTE_W +: BYTE_W] = in_data;
        cnt_n = base_cnt + 1'b1;
        done  = in_last | (cnt_n == LEN_W'(LANES));
      end else begin
        done  = in_last;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= 1'b0;
      last_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      data_q <= data_n;
      cnt_q  <= cnt_n;
      if (done) begin
        word_q <= 1'b1;
        last_q <= in_last;
      end else if (drain) begin
        word_q <= 1'b0;
        last_q <= 1'b0;
      end
    end
  end

  assign out_valid = word_q;
  assign out_data  = data_q;
  assign out_len   = cnt_q;
  assign out_last  = last_q;

endmodule

// File: rtl/pkt_lane_packer_chk.sv
module pkt_lane_packer_chk #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LEN_W  = $clog2(LANES + 1),
  localparam int DATA_W = LANES * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [LEN_W-1:0]  out_len,
  input logic              out_last
);

  logic hi_clear;
  always_comb begin
    hi_clear = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (LEN_W'(i) >= out_len && out_data[i*BYTE_W +: BYTE_W] != '0) hi_clear = 1'b0;
  end

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_len) && $stable(out_last));

  a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r2_mid_word_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_len == LEN_W'(LANES));

  a_r5_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len <= LEN_W'(LANES));

  a_r6_upper_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> hi_clear);

endmodule

bind pkt_lane_packer pkt_lane_packer_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_len(out_len), .out_last(out_last)
);

// File: tb/pkt_lane_packer_tb.sv
module pkt_lane_packer_tb;
  localparam int CLK_P  = 10;
  localparam int LANES  = 4;
  localparam int LEN_W  = $clog2(LANES + 1);
  localparam int DATA_W = LANES * 8;

  typedef struct packed { logic [7:0] b; logic last; logic empty; } beat_t;
  typedef struct packed { logic [DATA_W-1:0] d; logic [LEN_W-1:0] l; logic last; } word_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_empty = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_last;
  logic [DATA_W-1:0] out_data;
  logic [LEN_W-1:0] out_len;

  int checks = 0, fails = 0;
  beat_t beats[$];
  word_t exp_q[$];

  pkt_lane_packer #(.LANES(LANES), .BYTE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_empty(in_empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_len(out_len), .out_last(out_last));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected words are built from the packet rules alone
  task automatic add_packet(int n, bit by_empty, bit stray);
    logic [DATA_W-1:0] cur = '0;
    int cnt = 0;
    bit term_beat = by_empty || n == 0;
    if (stray) beats.push_back('{b: 8'h5a, last: 1'b0, empty: 1'b1});
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = 8'($urandom);
      beats.push_back('{b: v, last: !term_beat && i == n-1, empty: 1'b0});
      cur[cnt*8 +: 8] = v;
      cnt++;
      if (cnt == LANES || (!term_beat && i == n-1)) begin
        exp_q.push_back('{d: cur, l: LEN_W'(cnt), last: !term_beat && i == n-1});
        cur = '0;
        cnt = 0;
      end
    end
    if (term_beat) begin
      beats.push_back('{b: 8'h00, last: 1'b1, empty: 1'b1});
      exp_q.push_back('{d: cur, l: LEN_W'(cnt), last: 1'b1});
    end
  endtask

  task automatic run(int ready_pct, int valid_pct);
    bit prev_stall = 0;
    word_t prev = '0;
    int wd = 0;
    while ((beats.size() > 0 || exp_q.size() > 0) && wd < 100000) begin
      @(negedge clk);
      wd++;
      out_ready = ($urandom % 100) < ready_pct;
      in_valid  = beats.size() > 0 && ($urandom % 100) < valid_pct;
      if (beats.size() > 0) begin
        in_data = beats[0].b; in_last = beats[0].last; in_empty = beats[0].empty;
      end
      #1;
      check(in_ready == (!out_valid || out_ready), "R8", "in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
      if (prev_stall)
        check(out_valid && out_data == prev.d && out_len == prev.l && out_last == prev.last,
              "R7", "held word", 64'(out_data), 64'(prev.d));
      prev_stall = out_valid && !out_ready;
      prev = '{d: out_data, l: out_len, last: out_last};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R3", "unexpected word", 64'(out_data), 64'd0);
        else begin
          word_t e = exp_q.pop_front();
          string tag = !e.last ? "R2/R3/R6" : (e.l == LEN_W'(LANES) ? "R4" : "R5/R6");
          check(out_data == e.d, tag, "data", 64'(out_data), 64'(e.d));
          check(out_len == e.l && out_last == e.last, tag, "len,last", {out_len, out_last}, {e.l, e.last});
        end
      end
      if (in_valid && in_ready) void'(beats.pop_front());
    end
    if (wd >= 100000) check(0, "watchdog", "run hung", 64'(beats.size()), 64'd0);
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

    // R9: stray empty beat alone produces no word
    beats.push_back('{b: 8'h77, last: 1'b0, empty: 1'b1});
    run(100, 100);
    repeat (3) @(negedge clk);
    check(!out_valid, "R9", "word after stray empty beat", 64'(out_valid), 64'd0);

    add_packet(0, 0, 0);   // R5 zero-length packet
    add_packet(4, 0, 0);   // R4 full final word
    add_packet(4, 1, 0);   // R5 full word then zero-length close
    add_packet(1, 0, 1);   // R9 stray beat before packet
    add_packet(5, 0, 0);   // R3 spill into second word
    add_packet(8, 0, 0);   // R4 back to back multiples
    add_packet(8, 0, 0);
    add_packet(3, 1, 0);   // R5 close with three held
    run(100, 100);

    for (int k = 0; k < 300; k++)
      add_packet($urandom % 11, ($urandom % 4) == 0, ($urandom % 8) == 0);
    run(70, 85);
    for (int k = 0; k < 100; k++)
      add_packet($urandom % 9, ($urandom % 3) == 0, 0);
    run(30, 100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule